// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog peripheral with a 16-bit register interface. Its down-counter moves once per half-second timebase tick. Software keeps the counter from expiring by writing an ordered pair of key words to a service register. A single write cannot reload it, and neither can a wrong order.

When the counter runs out, the block raises one of two reset outputs. Control bits choose between an internal chip reset and an external reset pin. Once the counter is enabled, it cannot be stopped until the next reset.

The block also provides:
- a pretimeout interrupt with a status bit that software clears by writing 1;
- two active-low software reset request bits;
- a reset-cause flag that survives the reset the block itself requests;
- a one-shot power-down counter that pulses the interrupt line unless software turns it off.

Registers sit at byte offsets 0x0 (control), 0x2 (service), 0x4 (reset cause), 0x6 (interrupt control) and 0x8 (power-down control).

Top module: `keyed_wdog`

## Requirements
- R1: After reset the control register reads 0x0030, the power-down register reads 0x0001, `chipRstReq` is 0, `extRstN` is 1 and `intN` is 1.
- R2: With enable (control bit 2) set, the counter is loaded with the timeout field (control bits [15:8]). The timeout fires on the (field+1)-th tick after the load and stays asserted until `rstN`.
- R3: Writing 0x5555 to the service register and then 0xAAAA reloads the counter from the timeout field.
- R4: 0xAAAA written without an immediately preceding 0x5555 does not reload the counter. Any service write other than 0x5555 leaves the key checker waiting for 0x5555.
- R5: Once control bit 2 is 1, writing 0 to it has no effect until `rstN`.
- R6: Control bit 0 takes only the first control write after reset. While this bit is 1 and `lowPower` is high, ticks do not change the counter.
- R7: With control bit 3 at 1, a timeout drives `extRstN` low and leaves `chipRstReq` at 0. With bit 3 at 0, a timeout raises `chipRstReq` and leaves `extRstN` high.
- R8: Writing 0 to control bit 4 raises `chipRstReq`. Writing 0 to control bit 5 drives `extRstN` low.
- R9: Reset-cause register bit 1 reads 1 after a timeout and keeps that value through `rstN`. `porN` clears it, and so does a software internal reset request.
- R10: The interrupt status bit (interrupt control bit 14) is set by the tick that brings the counter to the pretimeout field (bits [7:0]) from above. When the enable bit (bit 15) is also set, `intN` goes low. Writing 1 to bit 14 clears the status.
- R11: When no 0 has been written to the power-down register, the PD_TICKS-th tick after reset drives `intN` low for exactly one clock. Writing 0 disables it, and a later nonzero write does not enable it again.
- R12: A timeout-field write while the counter runs does not change the count in progress; the new value is used at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rstN | input | 1 | Active-low block reset, asynchronous |
| porN | input | 1 | Active-low power-on reset; also clears the reset-cause flag |
| halfTick | input | 1 | One-clock pulse every half second |
| lowPower | input | 1 | Low-power mode indication |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Register byte offset |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for `addr`, combinational |
| chipRstReq | output | 1 | Internal chip reset request, active high |
| extRstN | output | 1 | External reset pin, active low |
| intN | output | 1 | Interrupt line, active low |

## Verification
The assertions assume that `halfTick` is a single-clock pulse, that `wrEn` lasts one clock per write, and that `porN` is never released while `rstN` is still low. The stimulus writes and ticks only through one-cycle tasks, each driven on the falling clock edge. `porN` is always raised together with `rstN`. The key-order properties also assume that no service write occurs in the same cycle as an enabling control write, and the bench never overlaps the two.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int REG_W = 16;
  localparam int ADDR_W = 4;
  localparam int CNT_W = 8;
  localparam logic [ADDR_W-1:0] A_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] A_SVC  = 4'h2;
  localparam logic [ADDR_W-1:0] A_RST  = 4'h4;
  localparam logic [ADDR_W-1:0] A_ICR  = 4'h6;
  localparam logic [ADDR_W-1:0] A_MISC = 4'h8;
  localparam logic [REG_W-1:0] KEY_ARM  = 16'h5555;
  localparam logic [REG_W-1:0] KEY_FIRE = 16'hAAAA;

  typedef struct packed {
    logic             load;
    logic [CNT_W-1:0] loadVal;
    logic             statClr;
  } kwdStb_t;
endpackage

// File: rtl/kwd_ctrl.sv
module kwd_ctrl
  import kwd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wrData,
  input  logic              preStat,
  input  logic              toutFlag,
  output logic [REG_W-1:0]  rdData,
  output kwdStb_t           stb,
  output logic [CNT_W-1:0]  wt,
  output logic [CNT_W-1:0]  pre,
  output logic              wda,
  output logic              srs,
  output logic              wre,
  output logic              wde,
  output logic              wdz,
  output logic              ie,
  output logic              pdEn,
  output logic              armed
);
  logic wzLock;
  logic ctrlWr, svcWr, icrWr, miscWr;

  assign ctrlWr = wrEn && (addr == A_CTRL);
  assign svcWr  = wrEn && (addr == A_SVC);
  assign icrWr  = wrEn && (addr == A_ICR);
  assign miscWr = wrEn && (addr == A_MISC);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wt     <= '0;
      pre    <= '0;
      wda    <= 1'b1;
      srs    <= 1'b1;
      wre    <= 1'b0;
      wde    <= 1'b0;
      wdz    <= 1'b0;
      wzLock <= 1'b0;
      ie     <= 1'b0;
      pdEn   <= 1'b1;
      armed  <= 1'b0;
    end else begin
      if (ctrlWr) begin
        wt  <= wrData[15:8];
        wda <= wrData[5];
        srs <= wrData[4];
        wre <= wrData[3];
        wde <= wde | wrData[2];          // cannot be cleared once set
        if (!wzLock) begin
          wdz    <= wrData[0];
          wzLock <= 1'b1;
        end
      end
      if (svcWr) armed <= (wrData == KEY_ARM);
      if (icrWr) begin
        ie  <= wrData[15];
        pre <= wrData[7:0];
      end
      if (miscWr) pdEn <= pdEn & (|wrData);
    end
  end

  always_comb begin
    stb.load    = (ctrlWr && wrData[2] && !wde) ||
                  (svcWr && (wrData == KEY_FIRE) && armed);
    stb.loadVal = ctrlWr ? wrData[15:8] : wt;
    stb.statClr = icrWr && wrData[14];
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdData = {wt, 2'b00, wda, srs, wre, wde, 1'b0, wdz};
      A_RST:   rdData = {14'b0, toutFlag, 1'b0};
      A_ICR:   rdData = {ie, preStat, 6'b0, pre};
      A_MISC:  rdData = {15'b0, pdEn};
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/kwd_count.sv
module kwd_count
  import kwd_pkg::*;
#(
  parameter int PD_TICKS = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             porN,
  input  logic             halfTick,
  input  logic             lowPower,
  input  kwdStb_t          stb,
  input  logic             wde,
  input  logic             wdz,
  input  logic [CNT_W-1:0] pre,
  input  logic             pdEn,
  input  logic             swRst,
  output logic [CNT_W-1:0] cnt,
  output logic             fired,
  output logic             preStat,
  output logic             toutFlag,
  output logic             pdPulse
);
  localparam int PD_W = $clog2(PD_TICKS + 1);
  localparam logic [PD_W-1:0] PD_LAST = PD_W'(PD_TICKS - 1);

  logic            tickRun, expire, preHit;
  logic [PD_W-1:0] pdCnt;
  logic            pdDone;

  assign tickRun = halfTick && wde && !fired && !(wdz && lowPower);
  assign expire  = tickRun && (cnt == '0);
  assign preHit  = tickRun && (cnt != '0) && ((cnt - CNT_W'(1)) == pre);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      fired   <= 1'b0;
      preStat <= 1'b0;
      pdCnt   <= '0;
      pdDone  <= 1'b0;
      pdPulse <= 1'b0;
    end else begin
      pdPulse <= 1'b0;
      if (stb.load)        cnt   <= stb.loadVal;
      else if (expire)     fired <= 1'b1;
      else if (tickRun)    cnt   <= cnt - CNT_W'(1);
      if (preHit)          preStat <= 1'b1;
      else if (stb.statClr) preStat <= 1'b0;
      if (halfTick && pdEn && !pdDone) begin
        if (pdCnt == PD_LAST) begin
          pdPulse <= 1'b1;
          pdDone  <= 1'b1;
        end else begin
          pdCnt <= pdCnt + PD_W'(1);
        end
      end
    end
  end

  // cause flag lives in the power-on domain so the requested reset keeps it
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)       toutFlag <= 1'b0;
    else if (expire) toutFlag <= 1'b1;
    else if (swRst)  toutFlag <= 1'b0;
  end
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import kwd_pkg::*;
#(
  parameter int PD_TICKS = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        porN,
  input  logic        halfTick,
  input  logic        lowPower,
  input  logic        wrEn,
  input  logic [3:0]  addr,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  output logic        chipRstReq,
  output logic        extRstN,
  output logic        intN
);
  kwdStb_t          stb;
  logic [CNT_W-1:0] wt, pre, cnt;
  logic wda, srs, wre, wde, wdz, ie, pdEn, armed;
  logic fired, preStat, toutFlag, pdPulse;

  kwd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .preStat(preStat), .toutFlag(toutFlag), .rdData(rdData), .stb(stb),
    .wt(wt), .pre(pre), .wda(wda), .srs(srs), .wre(wre), .wde(wde),
    .wdz(wdz), .ie(ie), .pdEn(pdEn), .armed(armed)
  );

  kwd_count #(.PD_TICKS(PD_TICKS)) u_count (
    .clk(clk), .rstN(rstN), .porN(porN), .halfTick(halfTick),
    .lowPower(lowPower), .stb(stb), .wde(wde), .wdz(wdz), .pre(pre),
    .pdEn(pdEn), .swRst(!srs), .cnt(cnt), .fired(fired),
    .preStat(preStat), .toutFlag(toutFlag), .pdPulse(pdPulse)
  );

  assign chipRstReq = (fired && !wre) || !srs;
  assign extRstN    = wda && !(fired && wre);
  assign intN       = !((ie && preStat) || pdPulse);
endmodule

// File: rtl/kwd_chk.sv
module kwd_chk
  import kwd_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              lowPower,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [REG_W-1:0]  wrData,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  wt,
  input logic              fired,
  input logic              wde,
  input logic              wdz,
  input logic              armed,
  input logic              pdPulse,
  input logic              stbLoad
);
  // R5
  wde_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    wde |=> wde);
  // R2
  fired_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    fired |=> fired);
  // R2
  fired_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fired && !stbLoad) |=> $stable(cnt));
  // R6
  suspend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wdz && lowPower && !stbLoad) |=> $stable(cnt));
  // R3
  key_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_SVC && wrData == KEY_FIRE && armed) |=> (cnt == $past(wt)));
  // R4
  key_disarm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_SVC && wrData != KEY_ARM) |=> !armed);
  // R11
  pd_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    pdPulse |=> !pdPulse);
endmodule

bind keyed_wdog kwd_chk u_chk (
  .clk(clk), .rstN(rstN), .lowPower(lowPower), .wrEn(wrEn), .addr(addr),
  .wrData(wrData), .cnt(cnt), .wt(wt), .fired(fired), .wde(wde), .wdz(wdz),
  .armed(armed), .pdPulse(pdPulse), .stbLoad(stb.load)
);

// File: tb/keyed_wdog_tb.sv
`timescale 1ns/1ps
module keyed_wdog_tb;
  localparam int PD_TICKS = 32;
  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_OUT = 3'd2,
                         OP_TICK = 3'd3, OP_LP = 3'd4;
  localparam logic [3:0] CT = 4'h0, SV = 4'h2, RS = 4'h4, IC = 4'h6, MS = 4'h8;
  localparam int NV = 46;
  // {op, requirement, offset, data/expected}; OUT data = {chipRstReq, extRstN, intN}
  localparam logic [26:0] VEC [NV] = '{
    {OP_RD, 4'd1, CT, 16'h0030},   // R1
    {OP_RD, 4'd1, MS, 16'h0001},   // R1
    {OP_OUT,4'd1, CT, 16'h0003},   // R1
    {OP_WR, 4'd11,MS, 16'h0000},   // R11 disable power-down
    {OP_RD, 4'd11,MS, 16'h0000},   // R11
    {OP_WR, 4'd6, CT, 16'h0331},   // R6 first write sets suspend bit
    {OP_RD, 4'd6, CT, 16'h0331},
    {OP_WR, 4'd5, CT, 16'h0334},   // enable, count=3
    {OP_RD, 4'd6, CT, 16'h0335},   // R6 suspend bit kept
    {OP_WR, 4'd5, CT, 16'h0330},   // R5 try to clear enable
    {OP_RD, 4'd5, CT, 16'h0335},
    {OP_WR, 4'd10,IC, 16'h8001},   // R10 ie=1, pre=1
    {OP_TICK,4'd2,CT, 16'h0000},   // count 2
    {OP_LP, 4'd6, CT, 16'h0001},
    {OP_TICK,4'd6,CT, 16'h0000},   // R6 suspended
    {OP_TICK,4'd6,CT, 16'h0000},
    {OP_LP, 4'd6, CT, 16'h0000},
    {OP_TICK,4'd6,CT, 16'h0000},   // count 1, pretimeout
    {OP_OUT,4'd10,CT, 16'h0002},   // R10
    {OP_RD, 4'd10,IC, 16'hC001},
    {OP_WR, 4'd10,IC, 16'hC001},   // clear status
    {OP_RD, 4'd10,IC, 16'h8001},
    {OP_OUT,4'd10,CT, 16'h0003},
    {OP_WR, 4'd3, SV, 16'h5555},   // R3
    {OP_WR, 4'd3, SV, 16'hAAAA},   // count 3
    {OP_WR, 4'd12,CT, 16'h0135},   // R12 timeout field 1 while running
    {OP_RD, 4'd12,CT, 16'h0135},
    {OP_TICK,4'd12,CT,16'h0000},   // 2
    {OP_TICK,4'd12,CT,16'h0000},   // 1, pretimeout
    {OP_OUT,4'd10,CT, 16'h0002},
    {OP_WR, 4'd10,IC, 16'hC001},
    {OP_TICK,4'd12,CT,16'h0000},   // 0
    {OP_OUT,4'd12,CT, 16'h0003},
    {OP_WR, 4'd3, SV, 16'h5555},
    {OP_WR, 4'd3, SV, 16'hAAAA},   // count 1
    {OP_WR, 4'd4, SV, 16'hAAAA},   // R4 lone second key
    {OP_TICK,4'd3,CT, 16'h0000},   // 0
    {OP_OUT,4'd3, CT, 16'h0003},   // R3
    {OP_WR, 4'd4, SV, 16'h5555},
    {OP_WR, 4'd4, SV, 16'h1234},   // R4 breaks the sequence
    {OP_WR, 4'd4, SV, 16'hAAAA},
    {OP_WR, 4'd4, SV, 16'hAAAA},
    {OP_TICK,4'd2,CT, 16'h0000},   // timeout
    {OP_OUT,4'd2, CT, 16'h0007},   // R2 R4
    {OP_RD, 4'd9, RS, 16'h0002},   // R9
    {OP_RD, 4'd12,CT, 16'h0135}
  };

  logic clk = 1'b0, rstN = 1'b0, porN = 1'b0, halfTick = 1'b0, lowPower = 1'b0;
  logic wrEn = 1'b0;
  logic [3:0] addr = '0;
  logic [15:0] wrData = '0, rdData;
  logic chipRstReq, extRstN, intN;
  int nChk = 0, nFail = 0;

  always #10 clk = ~clk;

  keyed_wdog #(.PD_TICKS(PD_TICKS)) u_dut (
    .clk(clk), .rstN(rstN), .porN(porN), .halfTick(halfTick),
    .lowPower(lowPower), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .chipRstReq(chipRstReq), .extRstN(extRstN), .intN(intN)
  );

  task automatic chk(input int req, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input int req, input logic [3:0] a, input logic [15:0] exp);
    @(negedge clk); addr = a; #1; chk(req, rdData, exp);
  endtask

  task automatic outs(input int req, input logic [2:0] exp);
    @(negedge clk); #1; chk(req, {13'b0, chipRstReq, extRstN, intN}, {13'b0, exp});
  endtask

  task automatic tick();
    @(negedge clk); halfTick = 1'b1;
    @(negedge clk); halfTick = 1'b0;
  endtask

  task automatic doReset(input logic withPor);
    @(negedge clk); rstN = 1'b0; porN = !withPor;
    repeat (2) @(negedge clk);
    rstN = 1'b1; porN = 1'b1;
  endtask

  initial begin
    #(200000 * 20);
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    doReset(1'b1);
    for (int i = 0; i < NV; i++) begin
      logic [26:0] e;
      e = VEC[i];
      case (e[26:24])
        OP_WR:   wr(e[19:16], e[15:0]);
        OP_RD:   rd(int'(e[23:20]), e[19:16], e[15:0]);
        OP_OUT:  outs(int'(e[23:20]), e[2:0]);
        OP_TICK: tick();
        default: begin @(negedge clk); lowPower = e[0]; end
      endcase
    end

    // R9 cause flag survives block reset, cleared by power-on reset
    doReset(1'b0);
    rd(9, RS, 16'h0002);
    rd(1, CT, 16'h0030);
    outs(1, 3'b011);
    doReset(1'b1);
    rd(9, RS, 16'h0000);

    // R7 external-only timeout
    wr(MS, 16'h0000);
    wr(CT, 16'h003C);
    tick();
    outs(7, 3'b001);
    rd(9, RS, 16'h0002);

    // R8 software reset bits, R9 software reset clears the cause
    doReset(1'b0);
    wr(MS, 16'h0000);
    rd(9, RS, 16'h0002);
    wr(CT, 16'h0020);
    outs(8, 3'b111);
    rd(9, RS, 16'h0000);
    wr(CT, 16'h0030);
    outs(8, 3'b011);
    wr(CT, 16'h0010);
    outs(8, 3'b001);

    // R11 power-down pulse of one clock
    doReset(1'b1);
    for (int k = 0; k < PD_TICKS - 1; k++) tick();
    outs(11, 3'b011);
    @(negedge clk); halfTick = 1'b1;
    @(negedge clk); halfTick = 1'b0; #1;
    chk(11, {15'b0, intN}, 16'h0000);
    outs(11, 3'b011);

    // R11 disabled counter stays quiet, re-enable ignored
    doReset(1'b1);
    wr(MS, 16'h0000);
    wr(MS, 16'h0001);
    rd(11, MS, 16'h0000);
    for (int k = 0; k < PD_TICKS + 2; k++) begin
      tick(); #1;
      chk(11, {15'b0, intN}, 16'h0001);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule